// File: doc/BRIEF.md
# Dual-Strobe EDO DRAM Device Responder

This block models, in synthesizable form, the memory side of a 16-bit dynamic RAM with extended-data-out page access and separate column strobes for each byte. It watches the row strobe, the two column strobes, write enable, output enable and the multiplexed address. All of these are assumed to be already synchronous to a fast internal clock. The block sorts the traffic into standby, word or byte reads, early and late writes, page-mode accesses, row-only refresh and column-before-row refresh. It backs the accesses with a small register array whose size is set by parameters.

A controller testbench uses it as a responder. Reads return stored data with per-byte drive enables, and read data is held in the extended-data-out manner. A refresh row counter advances on each column-before-row refresh. A single-cycle error pulse flags a row strobe that stayed active or inactive for fewer internal clock cycles than the configured minimum. Every input is registered once before it is decoded. Each output is registered once more, so an output reflects input conditions two clock edges earlier.

Top module: `edo_strobe_decoder`

## Requirements
- R1: The internal column strobe is active while either byte strobe is low. It goes inactive only once both are high, so a second lane falling, or one lane rising and falling again while the other stays low, starts no new access.
- R2: The row is taken from the address on the row-strobe falling edge, and the column is taken from the low address bits on the internal column-strobe falling edge.
- R3: If the column strobe is already low when the row strobe falls, the cycle is a refresh. The refresh row counter advances by one, both lanes stay undriven, and no write reaches the array.
- R4: A read loads the output data at the later of the column-strobe fall and the output-enable fall, provided write enable is high. With output enable high, no read takes place.
- R5: A write stores data at the later of the column-strobe fall and the write-enable fall. Only the lanes whose byte strobe is low at that point are written: the low strobe selects bits 7:0 and the upper strobe selects bits 15:8.
- R6: Lane enable `dq_oe[0]` (bits 7:0) or `dq_oe[1]` (bits 15:8) is 1 only while the row strobe, that lane's strobe and output enable are low and write enable is high. It is 0 in every other case.
- R7: Read data on `dq_out` stays unchanged after the column strobe rises, and is replaced only at a later read trigger.
- R8: A row cycle with both column strobes high drives no lane and leaves the refresh counter unchanged.
- R9: A cycle ends only when the row strobe and both column strobes are high. If the row strobe rises and falls again while a column strobe is still low, another refresh is performed.
- R10: A row strobe that rises after fewer than `T_RAS_MIN` low samples raises `timing_err` for one cycle. A row strobe low for at least that long raises nothing.
- R11: A row strobe that falls after fewer than `T_RP_MIN` high samples raises `timing_err` for one cycle.
- R12: The refresh counter steps by one per refresh and wraps from 4095 to 0.
- R13: After reset, `dq_oe`, `dq_out`, `ref_row` and `timing_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for bits 7:0, active low |
| ucas_n | input | 1 | Column strobe for bits 15:8, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Held read data |
| dq_oe | output | 2 | Per-lane drive enable |
| ref_row | output | 12 | Next row the internal refresh will use |
| timing_err | output | 1 | One-cycle pulse on a row-strobe width violation |

## Verification
The assertions assume that every strobe is held inactive during reset. They also assume that the column strobe falls at least one sample after the row strobe in an access cycle, so that it is never taken for a refresh. The stimulus drives all inputs at the falling clock edge and keeps the strobes high throughout reset. It always separates the row and column phases by at least one clock. It respects the minimum active and precharge widths, except in the two sequences that are meant to provoke the error pulse.

// File: rtl/edo_strobe_decoder.sv
`timescale 1ns/1ps
module edo_strobe_decoder #(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 10,
  parameter int REF_W     = 12,
  parameter int DATA_W    = 16,
  parameter int ROW_BITS  = 2,
  parameter int COL_BITS  = 3,
  parameter int T_RAS_MIN = 4,
  parameter int T_RP_MIN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [1:0]        dq_oe,
  output logic [REF_W-1:0]  ref_row,
  output logic              timing_err
);
  localparam int LANE_W = DATA_W / 2;
  localparam int IDX_W  = ROW_BITS + COL_BITS;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int CMAX   = (T_RAS_MIN > T_RP_MIN) ? T_RAS_MIN : T_RP_MIN;
  localparam int CNT_W  = $clog2(CMAX + 1);

  logic ras_q, ras_p, lcas_q, ucas_q, cas_p, we_q, we_p, oe_q, oe_p;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1; ras_p <= 1'b1;
      lcas_q <= 1'b1; ucas_q <= 1'b1; cas_p <= 1'b1;
      we_q <= 1'b1; we_p <= 1'b1;
      oe_q <= 1'b1; oe_p <= 1'b1;
      addr_q <= '0;
      din_q <= '0;
    end else begin
      ras_q <= ras_n;   ras_p <= ras_q;
      lcas_q <= lcas_n; ucas_q <= ucas_n; cas_p <= lcas_q & ucas_q;
      we_q <= we_n;     we_p <= we_q;
      oe_q <= oe_n;     oe_p <= oe_q;
      addr_q <= addr;
      din_q <= dq_in;
    end
  end

  logic cas_q;
  assign cas_q = lcas_q & ucas_q;

  logic ras_fall, ras_rise, cas_fall, oe_fall, we_fall;
  assign ras_fall = ras_p & ~ras_q;
  assign ras_rise = ~ras_p & ras_q;
  assign cas_fall = cas_p & ~cas_q;
  assign oe_fall  = oe_p & ~oe_q;
  assign we_fall  = we_p & ~we_q;

  logic cbr_r;
  logic cbr_start, active, rd_go, wr_go;
  assign cbr_start = ras_fall & ~cas_q;
  assign active    = ~ras_q & ~ras_p & ~cbr_r;
  assign rd_go     = active & we_q & ((cas_fall & ~oe_q) | (oe_fall & ~cas_q));
  assign wr_go     = active & ((cas_fall & ~we_q) | (we_fall & ~cas_q));

  logic [ROW_BITS-1:0] row_r;
  logic [COL_W-1:0]    col_r, col_now;
  logic [IDX_W-1:0]    idx;
  assign col_now = cas_fall ? addr_q[COL_W-1:0] : col_r;
  assign idx     = {row_r, col_now[COL_BITS-1:0]};

  logic unused_bits;
  assign unused_bits = ^{addr_q[ADDR_W-1:ROW_BITS], col_now[COL_W-1:COL_BITS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_r <= '0;
      col_r <= '0;
      cbr_r <= 1'b0;
      ref_row <= '0;
    end else begin
      if (ras_fall && cas_q) row_r <= addr_q[ROW_BITS-1:0];
      if (active && cas_fall) col_r <= addr_q[COL_W-1:0];
      if (cbr_start) begin
        cbr_r <= 1'b1;
        ref_row <= ref_row + 1'b1;
      end else if (ras_q && cas_q) begin
        cbr_r <= 1'b0;
      end
    end
  end

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (!lcas_q) mem[idx][LANE_W-1:0]      <= din_q[LANE_W-1:0];
      if (!ucas_q) mem[idx][DATA_W-1:LANE_W] <= din_q[DATA_W-1:LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 2'b00;
    end else begin
      if (rd_go) dq_out <= mem[idx];
      dq_oe[0] <= ~ras_q & ~lcas_q & ~oe_q & we_q & ~cbr_r & ~cbr_start;
      dq_oe[1] <= ~ras_q & ~ucas_q & ~oe_q & we_q & ~cbr_r & ~cbr_start;
    end
  end

  logic [CNT_W-1:0] lvl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_cnt <= CNT_W'(CMAX);
      timing_err <= 1'b0;
    end else begin
      if (ras_q != ras_p) lvl_cnt <= CNT_W'(1);
      else if (lvl_cnt != CNT_W'(CMAX)) lvl_cnt <= lvl_cnt + 1'b1;
      timing_err <= (ras_rise && lvl_cnt < CNT_W'(T_RAS_MIN)) ||
                    (ras_fall && lvl_cnt < CNT_W'(T_RP_MIN));
    end
  end
endmodule

module edo_strobe_decoder_chk #(
  parameter int DATA_W = 16,
  parameter int REF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              lcas_n,
  input logic              ucas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic [1:0]        dq_oe,
  input logic [REF_W-1:0]  ref_row,
  input logic              timing_err
);
  p_lane_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[0] |-> $past(!ras_n && !lcas_n && !oe_n && we_n, 2));

  p_lane_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[1] |-> $past(!ras_n && !ucas_n && !oe_n && we_n, 2));

  p_cbr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (dq_oe == 2'b00));

  p_ref_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (ref_row == REF_W'($past(ref_row) + 1'b1)));

  p_edo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out != $past(dq_out)) |-> $past(!(lcas_n && ucas_n), 2));

  // covers R11 as well: a pulse always follows a row-strobe edge
  p_err_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |-> ($past(ras_n, 2) != $past(ras_n, 3)));
endmodule

bind edo_strobe_decoder edo_strobe_decoder_chk #(.DATA_W(DATA_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
  .we_n(we_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
  .ref_row(ref_row), .timing_err(timing_err)
);

// File: tb/edo_strobe_decoder_bench.sv
`timescale 1ns/1ps
module edo_strobe_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic [11:0] ref_row;
  logic        timing_err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  edo_strobe_decoder u_edo_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ref_row(ref_row), .timing_err(timing_err)
  );

  // {row[31:28], col[27:24], lane mask[17:16], data[15:0]}
  localparam logic [31:0] VEC [8] = '{
    32'h0003_1234, 32'h1503_A5C3, 32'h3703_FFFF, 32'h2203_0000,
    32'h0001_BEEE, 32'h1502_7D11, 32'h3701_0000, 32'h2202_8000
  };

  logic [15:0] mdl [32];

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic do_write(input logic [1:0] row, input logic [2:0] col,
                          input logic [1:0] mask, input logic [15:0] data);
    addr = {10'd0, row}; ras_n = 1'b0; step(1);
    addr = {9'd0, col}; dq_in = data; we_n = 1'b0;
    lcas_n = ~mask[0]; ucas_n = ~mask[1]; step(4);
    idle_all(); step(4);
  endtask

  task automatic do_read(input logic [1:0] row, input logic [2:0] col,
                         output logic [15:0] data, output logic [1:0] en);
    addr = {10'd0, row}; ras_n = 1'b0; step(1);
    addr = {9'd0, col}; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step(2);
    data = dq_out; en = dq_oe; step(2);
    idle_all(); step(4);
  endtask

  task automatic cbr_once();
    lcas_n = 1'b0; ucas_n = 1'b0; step(1);
    ras_n = 1'b0; step(5);
    idle_all(); step(4);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [1:0]  en;
    logic [31:0] v;
    logic [4:0]  ix;

    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R13 dq_oe", {30'd0, dq_oe}, 32'd0);
    chk("R13 dq_out", {16'd0, dq_out}, 32'd0);
    chk("R13 ref_row", {20'd0, ref_row}, 32'd0);
    chk("R13 timing_err", {31'd0, timing_err}, 32'd0);

    // R2 R4 R5 R6: table of word and byte writes, each read back as a word
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      ix = {v[29:28], v[26:24]};
      if (v[16]) mdl[ix][7:0]  = v[7:0];
      if (v[17]) mdl[ix][15:8] = v[15:8];
      do_write(v[29:28], v[26:24], v[17:16], v[15:0]);
      do_read(v[29:28], v[26:24], rd, en);
      chk("R5 R2 vector readback", {16'd0, rd}, {16'd0, mdl[ix]});
      chk("R6 both lanes driven", {30'd0, en}, 32'd3);
    end

    // R7: page-mode hold of data past the column-strobe rise
    do_write(2'd0, 3'd5, 2'b11, 16'h5A5A);
    mdl[5'd5] = 16'h5A5A;
    addr = 12'd0; ras_n = 1'b0; step(1);
    addr = 12'd0; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step(2);
    chk("R7 first page read", {16'd0, dq_out}, {16'd0, mdl[5'd0]});
    lcas_n = 1'b1; ucas_n = 1'b1; addr = 12'd5; step(2);
    chk("R7 data held after strobe rise", {16'd0, dq_out}, {16'd0, mdl[5'd0]});
    chk("R6 lanes off with strobes high", {30'd0, dq_oe}, 32'd0);
    lcas_n = 1'b0; ucas_n = 1'b0; step(2);
    chk("R7 next page read", {16'd0, dq_out}, 32'h5A5A);
    idle_all(); step(4);

    // R4: output enable falling last starts the read
    addr = 12'd1; ras_n = 1'b0; step(1);
    addr = 12'd5; lcas_n = 1'b0; ucas_n = 1'b0; step(2);
    chk("R4 no read with oe high", {16'd0, dq_out}, 32'h5A5A);
    chk("R6 lanes off with oe high", {30'd0, dq_oe}, 32'd0);
    oe_n = 1'b0; step(2);
    chk("R4 read on oe fall", {16'd0, dq_out}, {16'd0, mdl[5'b01101]});
    chk("R6 lanes on after oe fall", {30'd0, dq_oe}, 32'd3);
    idle_all(); step(4);

    // R5: late write on write-enable fall, low lane only
    addr = 12'd2; ras_n = 1'b0; step(1);
    addr = 12'd2; lcas_n = 1'b0; step(1);
    dq_in = 16'h1357; we_n = 1'b0; step(3);
    idle_all(); step(4);
    mdl[5'b10010][7:0] = 8'h57;
    do_read(2'd2, 3'd2, rd, en);
    chk("R5 late byte write", {16'd0, rd}, {16'd0, mdl[5'b10010]});

    // R1: first strobe to fall defines the column, last to rise ends it
    addr = 12'd3; ras_n = 1'b0; step(1);
    addr = 12'd7; oe_n = 1'b0; lcas_n = 1'b0; step(1);
    addr = 12'd0; ucas_n = 1'b0; step(2);
    chk("R1 column from first fall", {16'd0, dq_out}, {16'd0, mdl[5'b11111]});
    chk("R1 lanes after second fall", {30'd0, dq_oe}, 32'd3);
    lcas_n = 1'b1; step(1);
    lcas_n = 1'b0; step(2);
    chk("R1 no new access while one strobe low", {16'd0, dq_out}, {16'd0, mdl[5'b11111]});
    idle_all(); step(4);

    // R3: column-before-row refresh, outputs quiet, counter advances
    addr = 12'd0; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; step(1);
    ras_n = 1'b0; step(2);
    chk("R3 counter advanced", {20'd0, ref_row}, 32'd1);
    chk("R3 lanes quiet", {30'd0, dq_oe}, 32'd0);
    step(3);
    // R9: row strobe cycles while the upper strobe stays low
    ras_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; step(4);
    ras_n = 1'b0; step(2);
    chk("R9 second refresh without cycle end", {20'd0, ref_row}, 32'd2);
    dq_in = 16'hFFFF; we_n = 1'b0; step(3);
    idle_all(); step(4);
    do_read(2'd0, 3'd0, rd, en);
    chk("R3 refresh wrote nothing", {16'd0, rd}, {16'd0, mdl[5'd0]});

    // R8: row-only refresh
    addr = 12'd0; oe_n = 1'b0; ras_n = 1'b0; step(5);
    chk("R8 no drive", {30'd0, dq_oe}, 32'd0);
    chk("R8 counter unchanged", {20'd0, ref_row}, 32'd2);
    idle_all(); step(4);

    // R10: active-width check
    ras_n = 1'b0; step(5);
    ras_n = 1'b1; step(2);
    chk("R10 no flag on legal width", {31'd0, timing_err}, 32'd0);
    step(3);
    ras_n = 1'b0; step(2);
    ras_n = 1'b1; step(2);
    chk("R10 short active flagged", {31'd0, timing_err}, 32'd1);
    step(3);

    // R11: precharge-width check
    ras_n = 1'b0; step(5);
    ras_n = 1'b1; step(1);
    ras_n = 1'b0; step(2);
    chk("R11 short precharge flagged", {31'd0, timing_err}, 32'd1);
    step(3);
    idle_all(); step(4);

    // R12: counter wrap
    for (int k = 0; k < 4093; k++) cbr_once();
    chk("R12 counter at top", {20'd0, ref_row}, 32'd4095);
    cbr_once();
    chk("R12 counter wrapped", {20'd0, ref_row}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule